// File: doc/BRIEF.md
# Two-Wire Bus Slave Transmitter

This block sits on a two-wire open-drain bus as an addressed slave. It watches the clock and data lines through synchronisers running on the system clock. It finds START and STOP conditions and shifts in the address byte that follows each START. When the 7-bit address matches its own address, it drives an acknowledge bit. A general call write is also acknowledged, but only when that option is enabled. A read request turns the block into a transmitter that shifts bytes out to the master. A write request, or a general call, is only flagged: the receive data path lives elsewhere.

Every bus event that needs software attention raises `irq_flag_o` and loads an 8-bit event code into `status_o`. While the flag is high, the block pulls SCL low, which stalls the master. Bytes to send arrive on a valid/ready port. `tx_ready_o` is high only while the flag is set and the block is waiting for the next byte. `tx_data_i` is taken on the cycle where `tx_valid_i` and `tx_ready_o` are both high. Taking the byte clears the flag and frees SCL. Until then, holding back `tx_valid_i` keeps the bus stretched, without limit. For events that need no byte, a pulse on `flag_clr_i` clears the flag.

If the acknowledge-enable input is low when the master answers a byte, that byte was the last one. The block then leaves the transfer and leaves SDA released, so any further clocks read back as ones.

Top module: `i2c_slave_tx`

## Requirements
- R1: After reset, `irq_flag_o` is 0 and both line drivers are off. `status_o` reads 0xF8 whenever `irq_flag_o` is 0.
- R2: After a START, the block shifts in 8 bits, MSB first, on the SCL rising edges. Bits [7:1] form the address and bit 0 is the direction (1 = read). With `enable_i` and `ack_en_i` both 1, an address equal to `own_addr_i[7:1]` makes the block drive SDA low through the ninth clock. Any other address gets no acknowledge and raises no flag.
- R3: Address 0x00 with direction 0 (general call) is acknowledged only when `own_addr_i[0]` is 1, and it reports status 0x70. Address 0x00 with direction 1 is never acknowledged.
- R4: The own address with direction 0 is acknowledged and reports status 0x60. After the flag is cleared, the block ignores the bus until the next START or STOP.
- R5: The own address with direction 1 is acknowledged and reports status 0xA8. The flag rises after the ninth SCL falling edge. `scl_oe_o` stays high while the flag is set.
- R6: `tx_ready_o` is high only while the block waits for a byte. A handshake clears the flag and releases SCL. The byte then goes out MSB first, and SDA changes only while SCL is low. The flag falls only on a handshake, a `flag_clr_i` pulse or `enable_i` low.
- R7: If the master acknowledges a byte while `ack_en_i` is 1, the block reports 0xB8 and requests the next byte.
- R8: If the master does not acknowledge a byte, the block reports 0xC0 and drops out of the transfer with SDA released. Further bytes then read 0xFF.
- R9: If `ack_en_i` is 0 at the ninth rising edge of a data byte, that byte is the last one. A master acknowledge then reports 0xC8, a master non-acknowledge reports 0xC0, and further bytes read 0xFF.
- R10: While `ack_en_i` is 0, the own address is not acknowledged and no flag is raised. Recognition works again once the input returns to 1.
- R11: With `enable_i` at 0, the block does not respond. The flag clears and both line drivers turn off on the next cycle.
- R12: A pulse on `arb_lost_i` before the next own-address read makes that read report 0xB0 instead of 0xA8. Data is then sent as usual.
- R13: A STOP or repeated START at any point ends the current transfer without any status. The next address phase is then decoded normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| own_addr_i | input | 8 | [7:1] own address, [0] general call enable |
| enable_i | input | 1 | Block enable |
| ack_en_i | input | 1 | Acknowledge enable |
| arb_lost_i | input | 1 | Lost-arbitration marker for the next read match |
| tx_data_i | input | 8 | Byte to transmit |
| tx_valid_i | input | 1 | Byte on `tx_data_i` is valid |
| tx_ready_o | output | 1 | Block waits for a byte |
| flag_clr_i | input | 1 | Clear the event flag without data |
| irq_flag_o | output | 1 | Event flag |
| status_o | output | 8 | Event code |

## Verification
Every one of the 128 addresses is sent with the read bit and again with the write bit. These sweeps separate an exact address match from near misses in single bits. They also separate general call accepted from general call refused by direction. Transfers carry bytes with alternating bits, with all ones and with all zeros, so a bit order or shift error shows up in the data read back. Each way a transfer can end is driven: master non-acknowledge, last byte taken from the acknowledge-enable input, disable, STOP partway through a byte and repeated START. After each ending, the next address phase must still decode.

// File: rtl/i2cst_pkg.sv
package i2cst_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_TXWAIT, S_TXBIT, S_TXACK, S_OFF
  } st_e;

  localparam logic [7:0] EV_NONE      = 8'hF8;
  localparam logic [7:0] EV_RD_ACK    = 8'hA8;
  localparam logic [7:0] EV_ARB_RD    = 8'hB0;
  localparam logic [7:0] EV_DATA_ACK  = 8'hB8;
  localparam logic [7:0] EV_DATA_NACK = 8'hC0;
  localparam logic [7:0] EV_LAST_ACK  = 8'hC8;
  localparam logic [7:0] EV_WR_ACK    = 8'h60;
  localparam logic [7:0] EV_GC_ACK    = 8'h70;
endpackage

// File: rtl/i2cst_sync.sv
module i2cst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) ff[0] <= 1'b1;
          else        ff[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) ff[g] <= 1'b1;
          else        ff[g] <= ff[g-1];
      end
    end
  endgenerate

  assign q = ff[STAGES-1];
endmodule

// File: rtl/i2cst_shreg.sv
module i2cst_shreg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] ld_val,
  input  logic          shift,
  input  logic          sin,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     q <= '0;
    else if (load)  q <= ld_val;
    else if (shift) q <= {q[DW-2:0], sin};
endmodule

// File: rtl/i2c_slave_tx.sv
module i2c_slave_tx
  import i2cst_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_oe_o,
  output logic          sda_oe_o,
  input  logic [DW-1:0] own_addr_i,
  input  logic          enable_i,
  input  logic          ack_en_i,
  input  logic          arb_lost_i,
  input  logic [DW-1:0] tx_data_i,
  input  logic          tx_valid_i,
  output logic          tx_ready_o,
  input  logic          flag_clr_i,
  output logic          irq_flag_o,
  output logic [7:0]    status_o
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST_BIT = CW'(DW);

  logic scl_s, sda_s, scl_d, sda_d;
  logic scl_rise, scl_fall, start_det, stop_det;
  st_e  state;
  logic [CW-1:0] bitcnt;
  logic [DW-1:0] sh_q;
  logic flag, sda_oe, rd, gc, arb_pend, m_ack, last;
  logic own_hit, gc_hit, tx_acc, sh_shift, sh_sin;

  i2cst_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (.clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s));
  i2cst_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (.clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

  assign own_hit = ack_en_i && (sh_q[DW-1:1] == own_addr_i[DW-1:1]);
  assign gc_hit  = ack_en_i && own_addr_i[0] && (sh_q[DW-1:1] == '0) && !sh_q[0];

  assign tx_ready_o = flag && (state == S_TXWAIT);
  assign tx_acc     = tx_valid_i && tx_ready_o;

  assign sh_shift = (state == S_ADDR  && scl_rise) ||
                    (state == S_TXBIT && scl_fall && bitcnt != LAST_BIT);
  assign sh_sin   = (state == S_ADDR) ? sda_s : 1'b1;

  i2cst_shreg #(.DW(DW)) u_shreg (
    .clk(clk), .rst_n(rst_n), .load(tx_acc), .ld_val(tx_data_i),
    .shift(sh_shift), .sin(sh_sin), .q(sh_q)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state    <= S_IDLE;
      bitcnt   <= '0;
      flag     <= 1'b0;
      status_o <= EV_NONE;
      sda_oe   <= 1'b0;
      rd       <= 1'b0;
      gc       <= 1'b0;
      arb_pend <= 1'b0;
      m_ack    <= 1'b0;
      last     <= 1'b0;
    end else if (!enable_i) begin
      state    <= S_IDLE;
      bitcnt   <= '0;
      flag     <= 1'b0;
      status_o <= EV_NONE;
      sda_oe   <= 1'b0;
      arb_pend <= 1'b0;
    end else begin
      if (arb_lost_i) arb_pend <= 1'b1;
      if (flag_clr_i || tx_acc) begin
        flag     <= 1'b0;
        status_o <= EV_NONE;
      end
      if (start_det) begin
        state  <= S_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          S_ADDR: begin
            if (scl_rise) bitcnt <= bitcnt + 1'b1;
            if (scl_fall && bitcnt == LAST_BIT) begin
              if (own_hit || gc_hit) begin
                sda_oe <= 1'b1;
                rd     <= sh_q[0] && !gc_hit;
                gc     <= gc_hit;
                state  <= S_AACK;
              end else begin
                state <= S_OFF;
              end
            end
          end
          S_AACK: if (scl_fall) begin
            sda_oe <= 1'b0;
            flag   <= 1'b1;
            bitcnt <= '0;
            if (rd) begin
              status_o <= arb_pend ? EV_ARB_RD : EV_RD_ACK;
              arb_pend <= 1'b0;
              state    <= S_TXWAIT;
            end else begin
              status_o <= gc ? EV_GC_ACK : EV_WR_ACK;
              state    <= S_OFF;
            end
          end
          S_TXWAIT: if (tx_acc) begin
            sda_oe <= ~tx_data_i[DW-1];
            bitcnt <= '0;
            state  <= S_TXBIT;
          end
          S_TXBIT: begin
            if (scl_rise) bitcnt <= bitcnt + 1'b1;
            if (scl_fall) begin
              if (bitcnt == LAST_BIT) begin
                sda_oe <= 1'b0;
                state  <= S_TXACK;
              end else begin
                sda_oe <= ~sh_q[DW-2];
              end
            end
          end
          S_TXACK: begin
            if (scl_rise) begin
              m_ack <= ~sda_s;
              last  <= ~ack_en_i;
            end
            if (scl_fall) begin
              flag <= 1'b1;
              if (!m_ack) begin
                status_o <= EV_DATA_NACK;
                state    <= S_OFF;
              end else if (last) begin
                status_o <= EV_LAST_ACK;
                state    <= S_OFF;
              end else begin
                status_o <= EV_DATA_ACK;
                state    <= S_TXWAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end

  assign irq_flag_o = flag;
  assign scl_oe_o   = flag;
  assign sda_oe_o   = sda_oe;
endmodule

// File: rtl/i2c_slave_tx_chk.sv
module i2c_slave_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe_o,
  input logic       scl_oe_o,
  input logic       irq_flag_o,
  input logic [7:0] status_o,
  input logic       flag_clr_i,
  input logic       tx_valid_i,
  input logic       tx_ready_o,
  input logic       enable_i
);
  a_r1_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_flag_o |-> status_o == 8'hF8);

  a_r1_event_code: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag_o) |-> status_o != 8'hF8);

  a_r5_flag_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag_o) |-> !scl_i);

  a_r5_hold_scl: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag_o) |-> scl_oe_o);

  a_r6_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> !scl_i);

  a_r6_flag_clear_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_flag_o) |-> $past(flag_clr_i || (tx_valid_i && tx_ready_o) || !enable_i));

  a_r8_end_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag_o) && (status_o == 8'hC0 || status_o == 8'hC8) |-> !sda_oe_o);

  a_r11_disable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> !irq_flag_o && !sda_oe_o);
endmodule

bind i2c_slave_tx i2c_slave_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
  .scl_oe_o(scl_oe_o), .irq_flag_o(irq_flag_o), .status_o(status_o),
  .flag_clr_i(flag_clr_i), .tx_valid_i(tx_valid_i), .tx_ready_o(tx_ready_o),
  .enable_i(enable_i)
);

// File: tb/i2c_slave_tx_bench.sv
module i2c_slave_tx_bench;
  localparam int Q = 6;
  localparam logic [6:0] OWN = 7'h5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic scl_line, sda_line, scl_oe, sda_oe;
  logic [7:0] own_addr = {OWN, 1'b1};
  logic enable = 1'b1, ack_en = 1'b1, arb_lost = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic tx_valid = 1'b0, tx_ready, flag_clr = 1'b0, flag;
  logic [7:0] status;
  int n_tests = 0, n_fail = 0;

  always #2 clk = ~clk;

  assign scl_line = !(m_scl_low || scl_oe);
  assign sda_line = !(m_sda_low || sda_oe);

  i2c_slave_tx u_i2c_slave_tx (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .own_addr_i(own_addr),
    .enable_i(enable), .ack_en_i(ack_en), .arb_lost_i(arb_lost),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
    .flag_clr_i(flag_clr), .irq_flag_o(flag), .status_o(status)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic scl_up();
    m_scl_low = 1'b0;
    for (int n = 0; n < 4000 && !scl_line; n++) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda_low = 1'b0; wq();
    scl_up(); wq();
    m_sda_low = 1'b1; wq();
    m_scl_low = 1'b1; wq();
  endtask

  task automatic bus_stop();
    m_sda_low = 1'b1; wq();
    scl_up(); wq();
    m_sda_low = 1'b0; wq();
  endtask

  task automatic clk_bit(input logic b, output logic r);
    m_sda_low = !b; wq();
    scl_up(); wq();
    r = sda_line; wq();
    m_scl_low = 1'b1; wq();
  endtask

  task automatic send_addr(input logic [6:0] a, input logic rd, output logic ack);
    logic [7:0] b;
    logic r;
    b = {a, rd};
    for (int i = 7; i >= 0; i--) clk_bit(b[i], r);
    clk_bit(1'b1, r);
    ack = !r;
  endtask

  task automatic read_byte(input logic mack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, r);
      d[i] = r;
    end
    clk_bit(!mack, r);
  endtask

  task automatic give(input logic [7:0] b);
    @(negedge clk); tx_data = b; tx_valid = 1'b1;
    @(negedge clk); tx_valid = 1'b0;
  endtask

  task automatic clr();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] d;
    logic [7:0] pat [5];
    pat[0] = 8'hA5; pat[1] = 8'h3C; pat[2] = 8'hFF; pat[3] = 8'h00; pat[4] = 8'h81;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 status", status, 8'hF8);
    check("R1 flag", flag, 0);
    check("R1 sda drive", sda_oe, 0);
    check("R1 scl drive", scl_oe, 0);

    // R2 / R5 sweep all addresses, read direction
    for (int a = 0; a < 128; a++) begin
      bus_start();
      send_addr(7'(a), 1'b1, ack);
      check("R2 read sweep ack", ack, (a == OWN));
      if (a == OWN) begin
        check("R5 status A8", status, 8'hA8);
        check("R5 scl held", scl_oe, 1);
        clr();
      end else check("R2 no flag", flag, 0);
      bus_stop();
    end

    // R3 / R4 sweep all addresses, write direction
    for (int a = 0; a < 128; a++) begin
      bus_start();
      send_addr(7'(a), 1'b0, ack);
      check("R3 R4 write sweep ack", ack, (a == OWN || a == 0));
      if (a == OWN) check("R4 status 60", status, 8'h60);
      else if (a == 0) check("R3 status 70", status, 8'h70);
      else check("R2 no flag on write", flag, 0);
      if (flag) clr();
      bus_stop();
    end

    // R3 general call refused when disabled
    own_addr = {OWN, 1'b0};
    bus_start(); send_addr(7'h00, 1'b0, ack);
    check("R3 gc disabled", ack, 0);
    check("R3 gc disabled flag", flag, 0);
    bus_stop();
    own_addr = {OWN, 1'b1};

    // R4 write then bus ignored
    bus_start(); send_addr(OWN, 1'b0, ack); clr();
    read_byte(1'b0, d);
    check("R4 ignored after write", d, 8'hFF);
    bus_stop();

    // R6 R7 R8 multi-byte transfer
    bus_start(); send_addr(OWN, 1'b1, ack);
    check("R6 ready", tx_ready, 1);
    for (int i = 0; i < 5; i++) begin
      give(pat[i]);
      check("R6 flag cleared", flag, 0);
      read_byte(i < 4, d);
      check("R6 data msb first", d, pat[i]);
      if (i < 4) check("R7 status B8", status, 8'hB8);
      else check("R8 status C0", status, 8'hC0);
    end
    check("R8 no ready", tx_ready, 0);
    clr();
    read_byte(1'b1, d);
    check("R8 ones after end", d, 8'hFF);
    check("R8 no flag after end", flag, 0);
    bus_stop();

    // R9 last byte via ack enable, master ACKs
    bus_start(); send_addr(OWN, 1'b1, ack);
    give(8'h96);
    ack_en = 1'b0;
    read_byte(1'b1, d);
    check("R9 last data", d, 8'h96);
    check("R9 status C8", status, 8'hC8);
    clr();
    read_byte(1'b1, d);
    check("R9 ones after last", d, 8'hFF);
    bus_stop();

    // R10 own address ignored while ack enable low, then resumes
    bus_start(); send_addr(OWN, 1'b1, ack);
    check("R10 no ack", ack, 0);
    check("R10 no flag", flag, 0);
    bus_stop();
    ack_en = 1'b1;
    bus_start(); send_addr(OWN, 1'b1, ack);
    check("R10 resumed ack", ack, 1);
    check("R10 resumed status", status, 8'hA8);
    clr(); bus_stop();

    // R11 disable
    bus_start(); send_addr(OWN, 1'b1, ack);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    check("R11 flag cleared", flag, 0);
    check("R11 scl released", scl_oe, 0);
    check("R11 status", status, 8'hF8);
    bus_stop();
    bus_start(); send_addr(OWN, 1'b1, ack);
    check("R11 no ack disabled", ack, 0);
    bus_stop();
    enable = 1'b1;

    // R12 arbitration-loss entry
    @(negedge clk); arb_lost = 1'b1; @(negedge clk); arb_lost = 1'b0;
    bus_start(); send_addr(OWN, 1'b1, ack);
    check("R12 status B0", status, 8'hB0);
    give(8'h5C);
    read_byte(1'b1, d);
    check("R12 data", d, 8'h5C);
    check("R12 then B8", status, 8'hB8);
    clr(); bus_stop();
    bus_start(); send_addr(OWN, 1'b1, ack);
    check("R12 one-shot", status, 8'hA8);
    clr(); bus_stop();

    // R13 stop mid-byte, then repeated start mid-byte
    bus_start(); send_addr(OWN, 1'b1, ack);
    give(8'hFF);
    for (int i = 0; i < 3; i++) clk_bit(1'b1, ack);
    bus_stop();
    check("R13 stop no flag", flag, 0);
    check("R13 stop status", status, 8'hF8);
    bus_start(); send_addr(OWN, 1'b1, ack);
    check("R13 after stop ack", ack, 1);
    check("R13 after stop status", status, 8'hA8);
    give(8'hFF);
    for (int i = 0; i < 2; i++) clk_bit(1'b1, ack);
    bus_start();
    check("R13 rstart no flag", flag, 0);
    send_addr(OWN, 1'b0, ack);
    check("R13 rstart ack", ack, 1);
    check("R13 rstart status", status, 8'h60);
    clr(); bus_stop();

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule